// File: doc/BRIEF.md
# Predicated Vector Element Issue Sequencer

This block turns one scalar-format operation into a stream of scalar element operations. Each of its three register operands (one destination and two sources) carries a flag that marks it as a vector. For every vector operand the register number steps up by one per element. A scalar operand keeps its base register number for every element. A predicate word and a vector length decide which elements are issued. Elements whose predicate bit is clear are skipped, and nothing is written for them. A per-operation invert flag complements the predicate before it is used.

An operation is accepted over a valid/ready pair. Element operations leave over a second valid/ready pair, at most one per cycle, with their register numbers already offset. If no operand is marked as a vector, the operation passes through as exactly one element with unchanged registers. Register numbers that would run past the last architectural register are reported on an error strobe instead of being issued. A done strobe marks the end of each operation, including operations that issue nothing.

Top module: `vecIssueSeq`

## Requirements
- R1: Enabled elements are issued in ascending element index, at most one per cycle, and `uopIdx` carries the index. Element i is enabled when i < `vecLen` and bit i of the effective predicate is 1.
- R2: For element i, each operand flagged as a vector gets register base+i and each unflagged operand gets its base unchanged.
- R3: With `predInv` = 1 the effective predicate is the bitwise complement of `predMask`. With `predInv` = 0 it is `predMask` itself.
- R4: When none of the three vector flags is set, exactly one element with index 0 and the unchanged base registers is issued, whatever `vecLen`, `predMask` and `predInv` hold.
- R5: Predicate bits at or above `vecLen` have no effect. `vecLen` may be anything from 0 to XLEN inclusive.
- R6: `done` is high for exactly one cycle per operation. It comes in the cycle after the last element hand-off, or in the cycle after acceptance when no element is enabled (`vecLen` = 0 or an all-zero effective predicate).
- R7: While `uopValid` is high and `uopReady` is low, the element and its register numbers stay unchanged, and the element is handed off only in a cycle where both are high.
- R8: An enabled element whose base+i exceeds 31 on any vector operand is not issued. Instead `wrapErr` is high for one cycle, and the sequence continues with the next element.
- R9: `reqReady` is high only when no operation is in progress. It is high after reset, with `uopValid`, `wrapErr` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request valid |
| reqReady | output | 1 | Sequencer idle, request accepted this cycle |
| reqRd | input | 5 | Destination base register |
| reqRs1 | input | 5 | First source base register |
| reqRs2 | input | 5 | Second source base register |
| reqRdVec | input | 1 | Destination is a vector |
| reqRs1Vec | input | 1 | First source is a vector |
| reqRs2Vec | input | 1 | Second source is a vector |
| vecLen | input | 6 | Vector length, 0 to XLEN |
| predMask | input | 32 | Predicate word |
| predInv | input | 1 | Complement predicate before use |
| uopValid | output | 1 | Element operation valid |
| uopReady | input | 1 | Downstream accepts element |
| uopRd | output | 5 | Element destination register |
| uopRs1 | output | 5 | Element first source register |
| uopRs2 | output | 5 | Element second source register |
| uopIdx | output | 5 | Element index |
| wrapErr | output | 1 | Element dropped: register number overflow |
| done | output | 1 | Operation finished |

## Verification
The assertions check the following on every cycle: held elements stay stable under backpressure, `done` lasts a single cycle, `wrapErr` and `uopValid` never overlap, the sequencer accepts nothing while busy, and element indices rise within an operation. The bench can show other properties only through its scenarios, because a property sees only the ports: which indices the predicate, invert flag and vector length select, the register offsets for each mix of scalar and vector operands, the single pass-through for all-scalar operations, and the empty operations. A behavioural queue model predicts every output in every cycle under several backpressure patterns.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_BUSY = 1'b1} visState_t;

  typedef struct packed {
    logic load;    // capture a new operation
    logic retire;  // drop the current element
  } visStrobe_t;
endpackage

// File: rtl/vis_datapath.sv
module vis_datapath
  import vis_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGW = 5,
  localparam int IDXW = $clog2(XLEN),
  localparam int LENW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  visStrobe_t      strobe,
  input  logic [REGW-1:0] reqRd,
  input  logic [REGW-1:0] reqRs1,
  input  logic [REGW-1:0] reqRs2,
  input  logic            reqRdVec,
  input  logic            reqRs1Vec,
  input  logic            reqRs2Vec,
  input  logic [LENW-1:0] vecLen,
  input  logic [XLEN-1:0] predMask,
  input  logic            predInv,
  output logic [REGW-1:0] curRd,
  output logic [REGW-1:0] curRs1,
  output logic [REGW-1:0] curRs2,
  output logic [IDXW-1:0] curIdx,
  output logic            curWrap,
  output logic            maskEmpty
);
  localparam int SUMW = ((IDXW > REGW) ? IDXW : REGW) + 1;

  logic [REGW-1:0] baseRd, baseRs1, baseRs2;
  logic            vecRd, vecRs1, vecRs2;
  logic [XLEN-1:0] remMask;
  logic [XLEN-1:0] lenMask;
  logic [XLEN-1:0] loadMask;
  logic [SUMW-1:0] sumRd, sumRs1, sumRs2;

  always_comb begin
    for (int i = 0; i < XLEN; i++) lenMask[i] = (i < int'(vecLen));
    if (!(reqRdVec || reqRs1Vec || reqRs2Vec))
      loadMask = XLEN'(1);
    else
      loadMask = (predInv ? ~predMask : predMask) & lenMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask <= '0;
      baseRd  <= '0;
      baseRs1 <= '0;
      baseRs2 <= '0;
      vecRd   <= 1'b0;
      vecRs1  <= 1'b0;
      vecRs2  <= 1'b0;
    end else if (strobe.load) begin
      remMask <= loadMask;
      baseRd  <= reqRd;
      baseRs1 <= reqRs1;
      baseRs2 <= reqRs2;
      vecRd   <= reqRdVec;
      vecRs1  <= reqRs1Vec;
      vecRs2  <= reqRs2Vec;
    end else if (strobe.retire) begin
      remMask <= remMask & (remMask - XLEN'(1));  // clear lowest set bit
    end
  end

  always_comb begin
    curIdx = '0;
    for (int i = XLEN - 1; i >= 0; i--)
      if (remMask[i]) curIdx = IDXW'(i);
  end

  assign maskEmpty = (remMask == '0);

  function automatic logic [SUMW-1:0] stepReg(input logic [REGW-1:0] base,
                                             input logic vec,
                                             input logic [IDXW-1:0] idx);
    return SUMW'(base) + (vec ? SUMW'(idx) : SUMW'(0));
  endfunction

  assign sumRd  = stepReg(baseRd, vecRd, curIdx);
  assign sumRs1 = stepReg(baseRs1, vecRs1, curIdx);
  assign sumRs2 = stepReg(baseRs2, vecRs2, curIdx);

  assign curRd   = sumRd[REGW-1:0];
  assign curRs1  = sumRs1[REGW-1:0];
  assign curRs2  = sumRs2[REGW-1:0];
  assign curWrap = (|sumRd[SUMW-1:REGW]) || (|sumRs1[SUMW-1:REGW]) ||
                   (|sumRs2[SUMW-1:REGW]);

  // R1
  idx_ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retire && !maskEmpty) |=> (maskEmpty || curIdx > $past(curIdx)));
endmodule

// File: rtl/vis_control.sv
module vis_control
  import vis_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       uopReady,
  input  logic       maskEmpty,
  input  logic       curWrap,
  output visStrobe_t strobe,
  output logic       reqReady,
  output logic       uopValid,
  output logic       wrapErr,
  output logic       done
);
  visState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    reqReady      = 1'b0;
    uopValid      = 1'b0;
    wrapErr       = 1'b0;
    done          = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = S_BUSY;
        end
      end
      S_BUSY: begin
        if (maskEmpty) begin
          done      = 1'b1;
          stateNext = S_IDLE;
        end else if (curWrap) begin
          wrapErr       = 1'b1;
          strobe.retire = 1'b1;
        end else begin
          uopValid      = 1'b1;
          strobe.retire = uopReady;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // R8
  wrap_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(uopValid && wrapErr));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/vecIssueSeq.sv
module vecIssueSeq
  import vis_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGW = 5,
  localparam int IDXW = $clog2(XLEN),
  localparam int LENW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [REGW-1:0] reqRd,
  input  logic [REGW-1:0] reqRs1,
  input  logic [REGW-1:0] reqRs2,
  input  logic            reqRdVec,
  input  logic            reqRs1Vec,
  input  logic            reqRs2Vec,
  input  logic [LENW-1:0] vecLen,
  input  logic [XLEN-1:0] predMask,
  input  logic            predInv,
  output logic            uopValid,
  input  logic            uopReady,
  output logic [REGW-1:0] uopRd,
  output logic [REGW-1:0] uopRs1,
  output logic [REGW-1:0] uopRs2,
  output logic [IDXW-1:0] uopIdx,
  output logic            wrapErr,
  output logic            done
);
  visStrobe_t strobe;
  logic       maskEmpty;
  logic       curWrap;

  vis_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .uopReady (uopReady),
    .maskEmpty(maskEmpty),
    .curWrap  (curWrap),
    .strobe   (strobe),
    .reqReady (reqReady),
    .uopValid (uopValid),
    .wrapErr  (wrapErr),
    .done     (done)
  );

  vis_datapath #(.XLEN(XLEN), .REGW(REGW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqRd    (reqRd),
    .reqRs1   (reqRs1),
    .reqRs2   (reqRs2),
    .reqRdVec (reqRdVec),
    .reqRs1Vec(reqRs1Vec),
    .reqRs2Vec(reqRs2Vec),
    .vecLen   (vecLen),
    .predMask (predMask),
    .predInv  (predInv),
    .curRd    (uopRd),
    .curRs1   (uopRs1),
    .curRs2   (uopRs2),
    .curIdx   (uopIdx),
    .curWrap  (curWrap),
    .maskEmpty(maskEmpty)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady) |=> (uopValid && $stable(uopIdx) &&
      $stable(uopRd) && $stable(uopRs1) && $stable(uopRs2)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!uopValid && !wrapErr && !done));
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);
endmodule

// File: tb/vecIssueSeq_test.sv
module vecIssueSeq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [4:0]  reqRd = '0, reqRs1 = '0, reqRs2 = '0;
  logic        reqRdVec = 1'b0, reqRs1Vec = 1'b0, reqRs2Vec = 1'b0;
  logic [5:0]  vecLen = '0;
  logic [31:0] predMask = '0;
  logic        predInv = 1'b0;
  logic        uopValid;
  logic        uopReady = 1'b1;
  logic [4:0]  uopRd, uopRs1, uopRs2, uopIdx;
  logic        wrapErr, done;

  always #2 clk = ~clk;

  vecIssueSeq uut (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int readyMode = 0;
  string tag = "R9";

  bit   mBusy = 0;
  int   mQ[$];
  int   mRd, mRs1, mRs2;
  bit   mRdV, mRs1V, mRs2V;
  int   issued = 0;
  int   wraps = 0;
  int   dones = 0;

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", t, what, act, exp, cyc);
    end
  endtask

  function automatic bit wrapsAt(input int i);
    return (mRdV && mRd + i > 31) || (mRs1V && mRs1 + i > 31) ||
           (mRs2V && mRs2 + i > 31);
  endfunction

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one clock: set ready, compare all outputs against the model, advance model
  task automatic step();
    int  h;
    bit  w;
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
    case (readyMode)
      0: uopReady = 1'b1;
      1: uopReady = cyc[0];
      default: uopReady = (cyc % 3 == 0);
    endcase
    #1;
    chk("R9", "reqReady", reqReady, !mBusy);
    chk("R6", "done", done, mBusy && mQ.size() == 0);
    h = (mBusy && mQ.size() != 0) ? mQ[0] : 0;
    w = mBusy && mQ.size() != 0 && wrapsAt(h);
    chk("R8", "wrapErr", wrapErr, w);
    chk(tag, "uopValid", uopValid, mBusy && mQ.size() != 0 && !w);
    if (mBusy && mQ.size() != 0 && !w) begin
      chk("R1", "uopIdx", uopIdx, h);
      chk("R2", "uopRd", uopRd, mRdV ? mRd + h : mRd);
      chk("R2", "uopRs1", uopRs1, mRs1V ? mRs1 + h : mRs1);
      chk("R2", "uopRs2", uopRs2, mRs2V ? mRs2 + h : mRs2);
    end
    // model advance for this edge
    if (!mBusy) begin
      if (reqValid) begin
        logic [31:0] eff;
        mRd = reqRd; mRs1 = reqRs1; mRs2 = reqRs2;
        mRdV = reqRdVec; mRs1V = reqRs1Vec; mRs2V = reqRs2Vec;
        mQ.delete();
        eff = predInv ? ~predMask : predMask;
        if (!(mRdV || mRs1V || mRs2V)) mQ.push_back(0);
        else
          for (int i = 0; i < int'(vecLen); i++)
            if (eff[i]) mQ.push_back(i);
        mBusy = 1;
      end
    end else if (mQ.size() == 0) begin
      mBusy = 0;
      dones++;
    end else if (w) begin
      void'(mQ.pop_front());
      wraps++;
    end else if (uopReady) begin
      void'(mQ.pop_front());
      issued++;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic runOp(input string t, input int rd, input int rs1, input int rs2,
                       input bit rdv, input bit rs1v, input bit rs2v,
                       input int vl, input logic [31:0] m, input bit inv,
                       input int expIssued, input int expWraps);
    tag = t;
    reqRd = 5'(rd); reqRs1 = 5'(rs1); reqRs2 = 5'(rs2);
    reqRdVec = rdv; reqRs1Vec = rs1v; reqRs2Vec = rs2v;
    vecLen = 6'(vl); predMask = m; predInv = inv;
    issued = 0; wraps = 0; dones = 0;
    reqValid = 1'b1;
    while (!mBusy) step();
    reqValid = 1'b0;
    while (mBusy) step();
    chk(t, "element count", issued, expIssued);
    chk("R8", "wrap count", wraps, expWraps);
    chk("R6", "done count", dones, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset reqReady", reqReady, 1);
    chk("R9", "reset uopValid", uopValid, 0);
    chk("R9", "reset done", done, 0);
    chk("R9", "reset wrapErr", wrapErr, 0);
    rstN = 1'b1;
    step();

    // R1 R2: all vector, sparse predicate 0xA5 over 8 elements -> 0,2,5,7
    runOp("R1", 4, 8, 16, 1, 1, 1, 8, 32'h0000_00A5, 0, 4, 0);
    // R2: mixed scalar/vector operands, alternating backpressure (R7)
    readyMode = 1;
    runOp("R2", 10, 3, 20, 1, 0, 1, 4, 32'hFFFF_FFFF, 0, 4, 0);
    // R7: heavy backpressure
    readyMode = 2;
    runOp("R7", 1, 2, 3, 0, 1, 0, 5, 32'h0000_001B, 0, 4, 0);
    readyMode = 0;
    // R3: inverted predicate -> elements 0..3 of 6
    runOp("R3", 0, 5, 9, 1, 1, 0, 6, 32'hFFFF_FFF0, 1, 4, 0);
    // R3: invert off with same mask -> elements 4,5
    runOp("R3", 0, 5, 9, 1, 1, 0, 6, 32'hFFFF_FFF0, 0, 2, 0);
    // R5: bits above vecLen ignored
    runOp("R5", 7, 7, 7, 0, 1, 1, 3, 32'hFFFF_FFFF, 0, 3, 0);
    // R5: full length XLEN, no wrap (base 0)
    readyMode = 1;
    runOp("R5", 0, 0, 0, 1, 1, 1, 32, 32'hFFFF_FFFF, 0, 32, 0);
    readyMode = 0;
    // R4: all scalar, VL 0 and empty mask still issue once
    runOp("R4", 11, 12, 13, 0, 0, 0, 0, 32'h0, 0, 1, 0);
    runOp("R4", 31, 30, 29, 0, 0, 0, 9, 32'h0000_00F0, 1, 1, 0);
    // R6: empty operations
    runOp("R6", 2, 4, 6, 1, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0);
    runOp("R6", 2, 4, 6, 1, 1, 0, 12, 32'h0, 0, 0, 0);
    runOp("R6", 2, 4, 6, 0, 1, 0, 12, 32'hFFFF_FFFF, 1, 0, 0);
    // R8: destination wraps at element 2
    runOp("R8", 30, 1, 1, 1, 0, 1, 4, 32'h0000_000F, 0, 2, 2);
    // R8: source wrap with sparse mask and backpressure
    readyMode = 2;
    runOp("R8", 0, 29, 5, 0, 1, 0, 8, 32'h0000_0055, 0, 2, 2);
    readyMode = 0;
    repeat (3) step();
    finishRun();
  end
endmodule